// File: doc/BRIEF.md
# Multi-Width Reloading Timer Bank

This block holds four hardware counters behind one single-cycle register port. Three of them are countdown timers: two 16 bits wide and one 32 bits wide. Each counts on one of two tick-enable inputs, which are produced by prescalers outside the block. Each can reload itself from a programmed value when it passes zero, and each raises a sticky interrupt on that underflow. The fourth counter is 40 bits wide. It counts up freely on the fast tick, is switched on by a bit in its upper value register, and never interrupts.

Software picks a period of N ticks by writing N-1 to a timer's load register. It then writes the control byte, first with the enable bit clear and then with it set. An interrupt is acknowledged by writing any value to that timer's clear register. The 40-bit counter serves as a fine-grained timestamp: its lower 32 bits read back as one word, and its upper bits read back together with the enable flag.

Top module: `cdtmr_bank`

## Requirements
- R1: After reset, every load, value and control register reads 0, all three interrupt outputs are low, and the 40-bit counter reads 0 and is stopped.
- R2: A load-register write to a disabled timer sets both its load value and its current count at once. The word at offset 0 of a timer reads the load value and offset 1 reads the count.
- R3: A counting step is a selected tick while the timer is enabled. In periodic mode (control bit 6 = 1), a step taken at count 0 reloads the count from the load value, so a load of N-1 gives an underflow every N steps.
- R4: In free-running mode (control bit 6 = 0), a step taken at count 0 wraps the count to all ones for that timer's width: 0xFFFF for the 16-bit timers and 0xFFFFFFFF for the 32-bit timer.
- R5: Every underflow sets that timer's pending bit. Output irq[i] follows the pending bit of timer i and stays high until it is cleared.
- R6: A write of any data to offset 3 of a timer clears its pending bit. When that write lands in the same cycle as a new underflow, the bit stays set.
- R7: A timer counts only while control bit 7 (enable) is 1. Control bit 3 = 1 selects tick_slow and bit 3 = 0 selects tick_fast. Ticks on the other input, and all ticks while the timer is disabled, leave the count unchanged.
- R8: A load-register write to an enabled timer leaves the count unchanged until that timer's next step. That step copies the new load value into the count with no decrement and no underflow.
- R9: Writing 1 to bit 8 of the counter's upper register (offset 13) makes the 40-bit counter increase by one on each tick_fast. Writing 0 to that bit stops the counter and holds it at 0. Offset 12 reads bits 31:0. Offset 13 reads the enable flag in bit 8 and counter bits 39:32 in bits 7:0.
- R10: bus_addr[4:2] selects the unit (0 to 2 for the timers, 3 for the 40-bit counter) and bus_addr[1:0] selects the register. Control reads return only bits 7, 6 and 3. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Slow tick enable, one clk cycle wide |
| tick_fast | input | 1 | Fast tick enable, one clk cycle wide |
| bus_addr | input | 5 | Word address of the register access |
| bus_wen | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 3 | Pending underflow interrupt, one bit per reloading timer |

## Verification
The assertions assume that a tick enable is high for single clk cycles only. They also assume that bus_addr and bus_wdata are steady in any cycle where bus_wen is high, so that one write reaches exactly one register. The stimulus changes bus inputs and ticks only on falling clock edges and holds each for a single cycle. Reads are taken in cycles with no tick and no write, so a read-back shows the state left by the previous rising edge.

// File: rtl/cdtmr_pkg.sv
package cdtmr_pkg;
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_PER_BIT = 6;
  localparam int CTL_SEL_BIT = 3;
  localparam int FR_EN_BIT   = 8;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic per;
    logic sel;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CTL_EN_BIT]  = c.en;
    w[CTL_PER_BIT] = c.per;
    w[CTL_SEL_BIT] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/cdtmr_reload.sv
module cdtmr_reload
  import cdtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_slow,
  input  logic         tick_fast,
  input  logic         ld_wr,
  input  logic [W-1:0] ld_data,
  input  logic         ctl_wr,
  input  ctrl_t        ctl_data,
  input  logic         clr_wr,
  output logic [W-1:0] load_q,
  output logic [W-1:0] count_q,
  output ctrl_t        ctrl_q,
  output logic         pend_q
);
  logic tick_sel;
  logic step;
  logic uf;
  logic ld_pend_q;

  function automatic logic [W-1:0] next_count(logic [W-1:0] cur, logic [W-1:0] ld,
                                              logic per, logic use_ld);
    if (use_ld)     return ld;
    if (cur == '0)  return per ? ld : '1;
    return cur - 1'b1;
  endfunction

  assign tick_sel = ctrl_q.sel ? tick_slow : tick_fast;
  assign step     = ctrl_q.en && tick_sel;
  assign uf       = step && !ld_pend_q && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q    <= '0;
      count_q   <= '0;
      ctrl_q    <= '0;
      pend_q    <= 1'b0;
      ld_pend_q <= 1'b0;
    end else begin
      if (ctl_wr) ctrl_q <= ctl_data;
      if (ld_wr)  load_q <= ld_data;
      if (ld_wr && !ctrl_q.en)
        count_q <= ld_data;
      else if (step)
        count_q <= next_count(count_q, load_q, ctrl_q.per, ld_pend_q);
      if (ld_wr)
        ld_pend_q <= ctrl_q.en;
      else if (step)
        ld_pend_q <= 1'b0;
      if (uf)
        pend_q <= 1'b1;
      else if (clr_wr)
        pend_q <= 1'b0;
    end
  end

  AST_UF_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> pend_q); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr_wr |=> pend_q); // R5
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !uf |=> !pend_q); // R6
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf && ctrl_q.per && !ld_wr |=> count_q == $past(load_q)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    uf && !ctrl_q.per && !ld_wr |=> count_q == '1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q.en && tick_sel) && !ld_wr |=> $stable(count_q)); // R7
  AST_LD_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr && ctrl_q.en && !tick_sel |=> $stable(count_q)); // R8
  AST_LD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend_q && step && !ld_wr |=> count_q == $past(load_q)); // R8
endmodule

// File: rtl/cdtmr_freerun.sv
module cdtmr_freerun #(
  parameter int FW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en_wr,
  input  logic          en_bit,
  output logic          en_q,
  output logic [FW-1:0] cnt_q
);
  function automatic logic [FW-1:0] bump(logic [FW-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (en_wr) en_q <= en_bit;
      if (!en_q)     cnt_q <= '0;
      else if (tick) cnt_q <= bump(cnt_q);
    end
  end

  AST_FR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick |=> cnt_q == $past(cnt_q) + 1'b1); // R9
  AST_FR_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> cnt_q == '0); // R9
  AST_FR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !tick |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/cdtmr_bank.sv
module cdtmr_bank
  import cdtmr_pkg::*;
#(
  parameter int W_NARROW = 16,
  parameter int W_WIDE   = 32,
  parameter int FW       = 40,
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int N_RLD    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N_RLD-1:0] irq
);
  localparam int REG_BITS  = 2;
  localparam int UNIT_BITS = AW - REG_BITS;
  localparam int FR_UNIT   = N_RLD;
  localparam int HI_W      = FW - DW;

  logic [UNIT_BITS-1:0] unit;
  reg_sel_e             rsel;
  logic [DW-1:0]        load_ext  [N_RLD];
  logic [DW-1:0]        count_ext [N_RLD];
  logic [DW-1:0]        ctrl_ext  [N_RLD];
  ctrl_t                wr_ctrl;
  logic                 fr_en;
  logic [FW-1:0]        fr_cnt;
  logic                 fr_wr;

  assign unit    = bus_addr[AW-1:REG_BITS];
  assign rsel    = reg_sel_e'(bus_addr[REG_BITS-1:0]);
  assign wr_ctrl = '{en: bus_wdata[CTL_EN_BIT], per: bus_wdata[CTL_PER_BIT],
                     sel: bus_wdata[CTL_SEL_BIT]};

  for (genvar g = 0; g < N_RLD; g++) begin : g_rld
    localparam int W = (g == N_RLD - 1) ? W_WIDE : W_NARROW;
    logic         hit;
    logic [W-1:0] ld_w;
    logic [W-1:0] cnt_w;
    ctrl_t        ctl_w;

    assign hit = bus_wen && (unit == UNIT_BITS'(g));

    cdtmr_reload #(.W(W)) i_rld (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .ld_wr     (hit && rsel == REG_LOAD),
      .ld_data   (bus_wdata[W-1:0]),
      .ctl_wr    (hit && rsel == REG_CTRL),
      .ctl_data  (wr_ctrl),
      .clr_wr    (hit && rsel == REG_CLEAR),
      .load_q    (ld_w),
      .count_q   (cnt_w),
      .ctrl_q    (ctl_w),
      .pend_q    (irq[g])
    );

    assign load_ext[g]  = DW'(ld_w);
    assign count_ext[g] = DW'(cnt_w);
    assign ctrl_ext[g]  = ctrl_to_word(ctl_w);
  end

  assign fr_wr = bus_wen && (unit == UNIT_BITS'(FR_UNIT)) && (rsel == REG_VALUE);

  cdtmr_freerun #(.FW(FW)) i_fr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_fast),
    .en_wr  (fr_wr),
    .en_bit (bus_wdata[FR_EN_BIT]),
    .en_q   (fr_en),
    .cnt_q  (fr_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (unit < UNIT_BITS'(N_RLD)) begin
      case (rsel)
        REG_LOAD:  bus_rdata = load_ext[unit[1:0]];
        REG_VALUE: bus_rdata = count_ext[unit[1:0]];
        REG_CTRL:  bus_rdata = ctrl_ext[unit[1:0]];
        default:   bus_rdata = '0;
      endcase
    end else if (unit == UNIT_BITS'(FR_UNIT)) begin
      if (rsel == REG_LOAD)
        bus_rdata = fr_cnt[DW-1:0];
      else if (rsel == REG_VALUE) begin
        bus_rdata[HI_W-1:0] = fr_cnt[FW-1:DW];
        bus_rdata[FR_EN_BIT] = fr_en;
      end
    end
  end

  AST_IRQ_RESET: assert property (@(posedge clk)
    $fell(rst_n) |=> irq == '0); // R1
endmodule

// File: tb/test_cdtmr_bank.sv
`timescale 1ns/1ps
module test_cdtmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [4:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  cdtmr_bank i_cdtmr_bank (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic wr(input logic [4:0] a, input logic [31:0] d,
                    input bit ts = 1'b0, input bit tf = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    tick_slow = ts; tick_fast = tf;
  endtask

  task automatic idle(input bit ts, input bit tf);
    @(negedge clk);
    bus_wen = 1'b0; tick_slow = ts; tick_fast = tf;
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_wen = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; bus_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_wen = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
    it.is_irq = 1'b1; it.addr = '0; it.exp = {29'b0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares each queued expectation after the following edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_irq ? {29'b0, irq} : bus_rdata;
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: %s addr %0d actual %h expected %h", it.tag,
                   it.is_irq ? "irq" : "read", it.addr, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(0, 0, "R1"); chk_rd(1, 0, "R1"); chk_rd(2, 0, "R1");
    chk_rd(9, 0, "R1"); chk_rd(12, 0, "R1"); chk_rd(13, 0, "R1");
    chk_irq(3'b000, "R1");

    // timer 0: period of 5 slow ticks
    wr(2, 32'h48);
    wr(0, 32'd4);
    chk_rd(1, 32'd4, "R2");
    chk_rd(0, 32'd4, "R2");
    chk_rd(2, 32'h48, "R10");
    wr(2, 32'hC8);
    for (int k = 0; k < 4; k++) idle(1, 0);
    chk_rd(1, 32'd0, "R3");
    chk_irq(3'b000, "R5");
    idle(1, 0);
    chk_rd(1, 32'd4, "R3");
    chk_irq(3'b001, "R5");
    for (int k = 0; k < 3; k++) idle(0, 1);
    chk_rd(1, 32'd4, "R7");
    chk_irq(3'b001, "R5");
    wr(3, 32'hDEAD_BEEF);
    chk_irq(3'b000, "R6");
    for (int k = 0; k < 4; k++) idle(1, 0);
    wr(3, 32'h0, 1'b1, 1'b0);  // clear coincides with underflow
    chk_irq(3'b001, "R6");
    chk_rd(1, 32'd4, "R3");
    wr(3, 32'h0);
    chk_irq(3'b000, "R6");

    // R8 deferred load while enabled
    wr(0, 32'd9);
    chk_rd(1, 32'd4, "R8");
    chk_rd(0, 32'd9, "R2");
    idle(1, 0);
    chk_rd(1, 32'd9, "R8");
    chk_irq(3'b000, "R8");
    idle(1, 0);
    chk_rd(1, 32'd8, "R8");
    wr(2, 32'h48);
    idle(1, 0); idle(1, 0);
    chk_rd(1, 32'd8, "R7");

    // timer 1: 16-bit wrap in free-running mode
    wr(4, 32'd1);
    wr(6, 32'h88);
    idle(1, 0); idle(1, 0);
    chk_rd(5, 32'h0000_FFFF, "R4");
    chk_irq(3'b010, "R5");
    idle(1, 0);
    chk_rd(5, 32'h0000_FFFE, "R4");

    // timer 2: 32-bit wrap on the fast tick
    wr(8, 32'd0);
    wr(10, 32'h80);
    idle(1, 0);
    chk_rd(9, 32'd0, "R7");
    idle(0, 1);
    chk_rd(9, 32'hFFFF_FFFF, "R4");
    chk_irq(3'b110, "R5");
    chk_rd(10, 32'h80, "R10");
    wr(7, 32'h0);
    wr(11, 32'h1234);
    chk_irq(3'b000, "R6");

    // R9 40-bit counter
    wr(13, 32'h100);
    for (int k = 0; k < 5; k++) idle(0, 1);
    chk_rd(12, 32'd5, "R9");
    chk_rd(13, 32'h100, "R9");
    idle(1, 0); idle(1, 0);
    chk_rd(12, 32'd5, "R9");
    wr(13, 32'h0);
    chk_rd(12, 32'd0, "R9");
    chk_rd(13, 32'd0, "R9");
    chk_rd(14, 32'd0, "R10");

    idle(0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule